// File: doc/BRIEF.md
# Asynchronous Parallel Flash Host Controller

This block sits inside a synchronous design and runs the pins of an asynchronous NOR-style parallel flash: an active-low chip select, an active-low read strobe, an active-low write strobe, a word address and a 16-bit data path. The data path is split into a drive value, a drive enable and a captured input so that the pad tristate can sit at the chip edge. Requests arrive one at a time over a valid/ready handshake. Each request is one of three operations: a single random read, a page read of one to eight consecutive words inside one aligned 8-word page, or a single command write. Read words come back one at a time with a one-cycle valid pulse.

Every strobe width is counted in clock cycles from four configuration inputs: the random access time, the page access time, the write pulse width and the write recovery time. A value of zero counts as one cycle. During a page read the chip select and read strobe stay low while the three low address bits step upward. A write opens the chip select one cycle before the write strobe falls, so the address is already settled at the later falling edge. The write strobe then rises one cycle before the chip select, so the data is still driven at the earlier rising edge. The read strobe stays high for the whole write.

Top module: `pflash_host`

## Requirements
- R1: After reset the chip select, read strobe and write strobe are high (inactive), the data drive enable is low, and `req_ready` is high.
- R2: Operation codes are 2'b00 single read, 2'b01 page read and 2'b10 write; 2'b11 acts as a single read. A single read holds chip select and read strobe low, with the write strobe high, for exactly the random access time in cycles. It samples `dq_i` in the last of those cycles and shows that word on `rd_data` with `rd_valid` and `rd_last` high for one cycle in the next cycle.
- R3: A page read keeps chip select and read strobe low without a break for all of its words. The first word takes the random access time and each later word takes the page access time. Address bits [2:0] go up by one per word while the upper bits stay fixed. The words are returned in address order, and `rd_last` is set only on the final one.
- R4: The page start offset is `req_addr[2:0]`. The number of words returned is the smaller of `req_count` and 8 minus the offset, and a `req_count` of 0 counts as 1. When the request is cut short at the page boundary, `rd_trunc` is high together with the final word; otherwise it stays low.
- R5: In a write, chip select falls one cycle before the write strobe falls. The address holds its value from the chip-select fall until the chip select rises.
- R6: In a write, the write strobe stays low for the write pulse width in cycles. It rises one cycle before the chip select rises, and the data is driven, holding the written value, up to and including the cycle in which the chip select is low and the write strobe is high again.
- R7: The read strobe stays high whenever the write strobe is low or the data bus is driven, and the data drive enable is always low in the cycle before the read strobe falls.
- R8: Between any two operations there is at least one cycle with all three strobes high, and `req_ready` is high only while all strobes are high and the data bus is released.
- R9: A timing input of 0 gives the same one-cycle width as a value of 1.
- R10: After a write, all strobes stay high for the write recovery time plus one cycle before `req_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge if valid |
| req_op | input | 2 | Operation code (R2) |
| req_addr | input | AW | Word address; bits [2:0] are the page offset |
| req_count | input | 4 | Page read word count, 1 to 8 |
| req_wdata | input | 16 | Write data |
| cfg_rand_acc | input | CW | Random access time in cycles |
| cfg_page_acc | input | CW | Page access time in cycles |
| cfg_wr_pulse | input | CW | Write strobe low width in cycles |
| cfg_wr_recov | input | CW | Recovery cycles after a write |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_addr | output | AW | Flash word address |
| dq_o | output | 16 | Data to drive onto the bus |
| dq_oe | output | 1 | Data bus drive enable |
| dq_i | input | 16 | Data sampled from the bus |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 16 | Read word |
| rd_last | output | 1 | Final word of the request |
| rd_trunc | output | 1 | Page request cut at the boundary, with final word |

## Verification
The assertions check the strobe relationships on every cycle: the read strobe never overlaps a write strobe or a driven bus, the bus is released before the read strobe falls, the write strobe falls only after the chip select with the address unchanged, and the data is held past the rising write strobe. They also check that the upper address bits stay fixed during a page, that a ready controller has every strobe high, and that each returned word follows a read-strobe cycle. Pulse lengths counted from the configuration inputs, returned data and its order, truncation at the page boundary, zero-value timing, and the recovery gap after a write can only be shown by the bench's scenarios, which count strobe cycles against the programmed values.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PAGE  = 2'b01,
    OP_WRITE = 2'b10,
    OP_ALT   = 2'b11
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_WREC,
    ST_GAP
  } st_t;

endpackage

// File: rtl/pflash_page_calc.sv
module pflash_page_calc #(
  parameter int PAGE_AW = 3,
  localparam int CNTW = PAGE_AW + 1,
  localparam int PAGE_WORDS = 1 << PAGE_AW
) (
  input  logic               is_page,
  input  logic [PAGE_AW-1:0] offset,
  input  logic [CNTW-1:0]    count,
  output logic [CNTW-1:0]    eff_count,
  output logic               truncated
);

  logic [CNTW-1:0] room;
  logic [CNTW-1:0] asked;

  always_comb begin
    room  = CNTW'(PAGE_WORDS) - {1'b0, offset};
    asked = (count == '0) ? CNTW'(1) : count;
    if (!is_page) begin
      eff_count = CNTW'(1);
      truncated = 1'b0;
    end else if (asked > room) begin
      eff_count = room;
      truncated = 1'b1;
    end else begin
      eff_count = asked;
      truncated = 1'b0;
    end
  end

endmodule

// File: rtl/pflash_timer.sv
module pflash_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(1);
    end else if (load) begin
      cnt <= (load_val == '0) ? CW'(1) : load_val;
    end else if (cnt > CW'(1)) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign done = (cnt == CW'(1));

  a_r9_count_never_zero: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int PAGE_AW = 3,
  localparam int CNTW = PAGE_AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [CNTW-1:0] eff_count,
  input  logic            eff_trunc,
  input  logic [CW-1:0]   cfg_rand_acc,
  input  logic [CW-1:0]   cfg_page_acc,
  input  logic [CW-1:0]   cfg_wr_pulse,
  input  logic [CW-1:0]   cfg_wr_recov,
  output logic            tmr_load,
  output logic [CW-1:0]   tmr_val,
  input  logic            tmr_done,
  output logic            fl_ce_n,
  output logic            fl_oe_n,
  output logic            fl_we_n,
  output logic [AW-1:0]   fl_addr,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe,
  input  logic [DW-1:0]   dq_i,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            rd_last,
  output logic            rd_trunc
);

  st_t             state;
  logic [CNTW-1:0] words_left;
  logic            trunc_q;
  logic            is_write;

  assign is_write  = (req_op == OP_WRITE);
  assign req_ready = (state == ST_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = cfg_rand_acc;
    unique case (state)
      ST_IDLE: tmr_load = req_valid && !is_write;
      ST_RD: begin
        tmr_load = tmr_done && (words_left != CNTW'(1));
        tmr_val  = cfg_page_acc;
      end
      ST_WSET: begin
        tmr_load = 1'b1;
        tmr_val  = cfg_wr_pulse;
      end
      ST_WHLD: begin
        tmr_load = 1'b1;
        tmr_val  = cfg_wr_recov;
      end
      default: tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      fl_ce_n    <= 1'b1;
      fl_oe_n    <= 1'b1;
      fl_we_n    <= 1'b1;
      fl_addr    <= '0;
      dq_o       <= '0;
      dq_oe      <= 1'b0;
      words_left <= '0;
      trunc_q    <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rd_last    <= 1'b0;
      rd_trunc   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_trunc <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            fl_addr <= req_addr;
            fl_ce_n <= 1'b0;
            if (is_write) begin
              dq_o  <= req_wdata;
              dq_oe <= 1'b1;
              state <= ST_WSET;
            end else begin
              fl_oe_n    <= 1'b0;
              words_left <= eff_count;
              trunc_q    <= eff_trunc;
              state      <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (tmr_done) begin
            rd_data  <= dq_i;
            rd_valid <= 1'b1;
            if (words_left == CNTW'(1)) begin
              rd_last  <= 1'b1;
              rd_trunc <= trunc_q;
              fl_ce_n  <= 1'b1;
              fl_oe_n  <= 1'b1;
              state    <= ST_GAP;
            end else begin
              words_left           <= words_left - CNTW'(1);
              fl_addr[PAGE_AW-1:0] <= fl_addr[PAGE_AW-1:0] + PAGE_AW'(1);
            end
          end
        end
        ST_WSET: begin
          fl_we_n <= 1'b0;
          state   <= ST_WPUL;
        end
        ST_WPUL: begin
          if (tmr_done) begin
            fl_we_n <= 1'b1;
            state   <= ST_WHLD;
          end
        end
        ST_WHLD: begin
          fl_ce_n <= 1'b1;
          dq_oe   <= 1'b0;
          state   <= ST_WREC;
        end
        ST_WREC: begin
          if (tmr_done) state <= ST_GAP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: read strobe exclusive with write activity
  a_r7_oe_quiet_in_write: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n || dq_oe) |-> fl_oe_n);
  a_r7_bus_released_first: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_oe_n) |-> !$past(dq_oe));
  // R5: write strobe falls after chip select with address settled
  a_r5_we_after_ce: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> (!$past(fl_ce_n) && $stable(fl_addr) && $past(dq_oe)));
  // R6: data still driven when write strobe rises
  a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (!fl_ce_n && dq_oe && $stable(dq_o)));
  // R3: upper address fixed while a page read is open
  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!fl_oe_n && $past(!fl_oe_n)) |->
      (fl_addr[AW-1:PAGE_AW] == $past(fl_addr[AW-1:PAGE_AW])));
  // R8: ready only with every strobe high and bus released
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (fl_ce_n && fl_oe_n && fl_we_n && !dq_oe));
  // R2: a returned word follows a read-strobe cycle
  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(!fl_oe_n) && $past(!fl_ce_n)));
  // R4: effective page count stays inside the page
  a_r4_inside_page: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |->
      ((eff_count != '0) &&
       ({1'b0, req_addr[PAGE_AW-1:0]} + eff_count <= CNTW'(1 << PAGE_AW))));

endmodule

// File: rtl/pflash_host.sv
module pflash_host
  import pflash_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int PAGE_AW = 3,
  localparam int CNTW = PAGE_AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [CNTW-1:0] req_count,
  input  logic [DW-1:0]   req_wdata,
  input  logic [CW-1:0]   cfg_rand_acc,
  input  logic [CW-1:0]   cfg_page_acc,
  input  logic [CW-1:0]   cfg_wr_pulse,
  input  logic [CW-1:0]   cfg_wr_recov,
  output logic            fl_ce_n,
  output logic            fl_oe_n,
  output logic            fl_we_n,
  output logic [AW-1:0]   fl_addr,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe,
  input  logic [DW-1:0]   dq_i,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            rd_last,
  output logic            rd_trunc
);

  logic [CNTW-1:0] eff_count;
  logic            eff_trunc;
  logic            tmr_load;
  logic [CW-1:0]   tmr_val;
  logic            tmr_done;

  pflash_page_calc #(.PAGE_AW(PAGE_AW)) u_calc (
    .is_page   (req_op == OP_PAGE),
    .offset    (req_addr[PAGE_AW-1:0]),
    .count     (req_count),
    .eff_count (eff_count),
    .truncated (eff_trunc)
  );

  pflash_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  pflash_seq #(.AW(AW), .DW(DW), .CW(CW), .PAGE_AW(PAGE_AW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .eff_count    (eff_count),
    .eff_trunc    (eff_trunc),
    .cfg_rand_acc (cfg_rand_acc),
    .cfg_page_acc (cfg_page_acc),
    .cfg_wr_pulse (cfg_wr_pulse),
    .cfg_wr_recov (cfg_wr_recov),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .tmr_done     (tmr_done),
    .fl_ce_n      (fl_ce_n),
    .fl_oe_n      (fl_oe_n),
    .fl_we_n      (fl_we_n),
    .fl_addr      (fl_addr),
    .dq_o         (dq_o),
    .dq_oe        (dq_oe),
    .dq_i         (dq_i),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_last      (rd_last),
    .rd_trunc     (rd_trunc)
  );

endmodule

// File: tb/tb_pflash_host.sv
module tb_pflash_host;

  localparam int AW = 22;
  localparam int CW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_count = 4'd1;
  logic [15:0]   req_wdata = '0;
  logic [CW-1:0] c_racc = 8'd2, c_pacc = 8'd1, c_wpul = 8'd2, c_wrec = 8'd1;
  logic          fl_ce_n, fl_oe_n, fl_we_n, dq_oe;
  logic [AW-1:0] fl_addr;
  logic [15:0]   dq_o, dq_i, rd_data;
  logic          rd_valid, rd_last, rd_trunc;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] fmodel(input logic [AW-1:0] a);
    return a[15:0] ^ {a[21:16], 10'h155};
  endfunction

  assign dq_i = (!fl_ce_n && !fl_oe_n) ? fmodel(fl_addr) : 16'hDEAD;

  pflash_host dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_count(req_count),
    .req_wdata(req_wdata), .cfg_rand_acc(c_racc), .cfg_page_acc(c_pacc),
    .cfg_wr_pulse(c_wpul), .cfg_wr_recov(c_wrec), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .rd_trunc(rd_trunc)
  );

  // trace of one operation
  int ce_cnt, oe_cnt, we_cnt, drv_cnt, tail, viol, bad_wr;
  int ce_first, ce_last, we_first, we_last, drv_last, nrd;
  logic [15:0] rbuf [8];
  logic        rlast [8];
  logic        rtr [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [3:0] n, input logic [15:0] wd);
    int cyc;
    ce_cnt = 0; oe_cnt = 0; we_cnt = 0; drv_cnt = 0; tail = 0; viol = 0; bad_wr = 0;
    ce_first = -1; ce_last = -1; we_first = -1; we_last = -1; drv_last = -1; nrd = 0;
    for (int k = 0; k < 8; k++) begin rbuf[k] = '0; rlast[k] = 0; rtr[k] = 0; end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_count = n; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    for (int i = 0; i < 600 && !req_ready; i++) begin
      cyc++;
      if (!fl_ce_n) begin
        ce_cnt++; ce_last = cyc;
        if (ce_first < 0) ce_first = cyc;
      end else if (ce_cnt > 0) tail++;
      if (!fl_oe_n) oe_cnt++;
      if (!fl_we_n) begin
        we_cnt++; we_last = cyc;
        if (we_first < 0) we_first = cyc;
        if (fl_addr != a || dq_o != wd || !dq_oe) bad_wr++;
      end
      if (dq_oe) begin drv_cnt++; drv_last = cyc; end
      if (!fl_oe_n && (dq_oe || !fl_we_n)) viol++;
      if (fl_ce_n && (!fl_we_n || !fl_oe_n)) viol++;
      if (rd_valid && nrd < 8) begin
        rbuf[nrd] = rd_data; rlast[nrd] = rd_last; rtr[nrd] = rd_trunc; nrd++;
      end
      @(negedge clk);
    end
    if (!req_ready) chk(0, "watchdog op hung", 0, 1);
  endtask

  task automatic t_reset;
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R1 strobes high after reset",
        {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    chk(!dq_oe, "R1 bus released after reset", dq_oe, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_read(input logic [1:0] op, input logic [AW-1:0] a,
                        input int racc, input string tag);
    int expw;
    c_racc = CW'(racc);
    expw = (racc == 0) ? 1 : racc;
    run_op(op, a, 4'd1, 16'h0);
    chk(oe_cnt == expw && ce_cnt == expw, {tag, " access width"}, oe_cnt, expw);
    chk(nrd == 1, {tag, " word count"}, nrd, 1);
    chk(rbuf[0] == fmodel(a), {tag, " data"}, rbuf[0], fmodel(a));
    chk(rlast[0] && !rtr[0], {tag, " last/trunc flags"}, {rlast[0], rtr[0]}, 2);
    chk(we_cnt == 0 && drv_cnt == 0 && viol == 0, "R7 read keeps write quiet", viol + we_cnt, 0);
    chk(tail >= 1, "R8 idle gap after read", tail, 1);
  endtask

  task automatic t_page(input logic [AW-1:0] a, input logic [3:0] n,
                        input int racc, input int pacc, input int expn, input bit exptr);
    int expw;
    c_racc = CW'(racc); c_pacc = CW'(pacc);
    run_op(2'b01, a, n, 16'h0);
    expw = racc + (expn - 1) * pacc;
    chk(oe_cnt == expw && ce_cnt == expw, "R3 page strobe width unbroken", oe_cnt, expw);
    chk(nrd == expn, "R4 page word count", nrd, expn);
    for (int k = 0; k < expn && k < 8; k++) begin
      logic [AW-1:0] ea;
      ea = a + AW'(k);
      chk(rbuf[k] == fmodel(ea), "R3 page word data/order", rbuf[k], fmodel(ea));
      chk(rlast[k] == (k == expn - 1), "R3 last flag position", rlast[k], k == expn - 1);
    end
    chk(rtr[expn-1] == exptr, "R4 truncation flag", rtr[expn-1], exptr);
    chk(viol == 0, "R7 page read strobes", viol, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [15:0] wd,
                         input int wp, input int wr, input string tag);
    int ewp, ewr;
    c_wpul = CW'(wp); c_wrec = CW'(wr);
    ewp = (wp == 0) ? 1 : wp;
    ewr = (wr == 0) ? 1 : wr;
    run_op(2'b10, a, 4'd1, wd);
    chk(we_first == ce_first + 1, "R5 ce falls one cycle before we", we_first, ce_first + 1);
    chk(bad_wr == 0, "R5 address/data stable while we low", bad_wr, 0);
    chk(we_cnt == ewp, {tag, " write pulse width"}, we_cnt, ewp);
    chk(ce_last == we_last + 1 && drv_last == ce_last, "R6 data held past we rise",
        drv_last, we_last + 1);
    chk(oe_cnt == 0 && viol == 0, "R7 oe high through write", oe_cnt + viol, 0);
    chk(tail == ewr + 1, {tag, " recovery gap"}, tail, ewr + 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(2'b00, 22'h12345, 3, "R2 single read");
    t_read(2'b11, 22'h2ABCD, 2, "R2 alternate code read");
    t_read(2'b00, 22'h00777, 0, "R9 zero access time read");
    t_page(22'h0A3F0, 4'd8, 4, 2, 8, 1'b0);
    t_page(22'h15555, 4'd6, 3, 1, 3, 1'b1);
    t_page(22'h01232, 4'd0, 2, 2, 1, 1'b0);
    t_page(22'h31F06, 4'd2, 2, 3, 2, 1'b0);
    t_page(22'h31F07, 4'd2, 1, 1, 1, 1'b1);
    t_write(22'h00AAA, 16'hC0DE, 3, 2, "R10 R6");
    t_write(22'h3FFFF, 16'h5A5A, 0, 0, "R9");
    t_read(2'b00, 22'h00AAA, 1, "R8 read after write");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule